// File: doc/BRIEF.md
# Flash read-while-write arbiter

This block stands between a simple read port and a flash array built from two banks. Each bank reports, on a done line, whether a high-voltage program or erase operation is running. A read whose target bank is busy is not sent to the array. The block saves the read's address and attributes and then applies the response policy set for that bank. It can hold the read and replay it later, signal software, abort the running operation, or return a bus error at once.

When the bank becomes idle again, the saved address phase is sent to the array as a synthetic request. The returned data then completes the original read. Only one read is in flight at a time. Four sticky interrupt flags, one notify flag and one abort flag for each bank, are ORed into a single interrupt request.

Top module: `flash_rww_ctrl`

## Requirements
- R1: After reset, `rd_rdy` is 1 and `irq_flags`, `irq` and `bank_abort` are 0. Both bank policy fields reset to 3'b111.
- R2: Address bit AW-1 selects the target bank (0 = bank 0, 1 = bank 1). Only the target bank's `bank_done` matters, and a bank counts as busy while its `bank_done` is 0. `fl_req` is never raised while the target bank is busy.
- R3: Under policy 3'b111, a read to a busy bank is held with no response, no flag and no abort. Once that bank's done line returns high, the read is replayed and completes with the array data. The array model returns {addr, ~addr} for each address.
- R4: If the target bank's done line falls after a read has been sent to the array and before its data returns, the read is stalled. It is then sent to the array a second time with the same address and attributes.
- R5: Under policy 3'b110, the read stalls as under R3 and sets the notify flag, which is `irq_flags` bit 0 for bank 0 or bit 1 for bank 1.
- R6: Under policy 3'b101, the read stalls and replays, and `bank_abort` pulses for exactly one cycle on the target bank only. No flag is set.
- R7: Under policy 3'b100, the block acts as under R6 and also sets the abort flag, which is `irq_flags` bit 2 for bank 0 or bit 3 for bank 1. `bank_abort` is never raised for a bank whose policy is not 3'b10x.
- R8: Under any policy with bit 2 clear (3'b0xx), a read to a busy bank ends one cycle after acceptance with a one-cycle `rd_err`. No stall occurs, no array request is made and no flag is set. If the bank is idle, the read completes normally.
- R9: Flags stay set until software writes 1 to the matching `irq_clr` bit. Writing 1 to any other bit leaves the flag unchanged. `irq` is the OR of all four flags.
- R10: `rd_rdy` is low from the cycle after a read is accepted until its response. `rd_ack` and `rd_err` never occur together, and responses come back in request order.
- R11: `ctl_we` loads `ctl_wdata[2:0]` into bank 0's policy and `ctl_wdata[5:3]` into bank 1's policy. The new policy applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_req | input | 1 | Read address phase valid |
| rd_addr | input | AW | Read address; the MSB selects the bank |
| rd_attr | input | TW | Transfer attributes |
| rd_rdy | output | 1 | Block can accept a read |
| rd_ack | output | 1 | One-cycle pulse; rd_data is valid |
| rd_err | output | 1 | One-cycle error response |
| rd_data | output | DW | Read data |
| ctl_we | input | 1 | Policy write strobe |
| ctl_wdata | input | 6 | Policies: bank 1 in [5:3], bank 0 in [2:0] |
| irq_clr | input | 4 | Write-1-to-clear flags |
| irq_flags | output | 4 | {abort1, abort0, notify1, notify0} |
| irq | output | 1 | Combined interrupt request |
| bank_done | input | 2 | Per-bank operation idle |
| bank_abort | output | 2 | Per-bank abort pulse |
| fl_req | output | 1 | Array read request |
| fl_addr | output | AW | Array address |
| fl_attr | output | TW | Array attributes |
| fl_rvalid | input | 1 | Array data valid |
| fl_rdata | input | DW | Array data |

## Verification
The assertions check the following on every cycle: the abort pulse is one cycle long and goes to a single bank, aborts occur only under an abort policy, flags stay sticky, `fl_req` is never raised to a busy bank, and `rd_ack` and `rd_err` are mutually exclusive. The bench scenarios cover the rest. They show that a stalled read returns the correct data only after done rises, and that a read interrupted after issue reaches the array twice with the same attributes. They also show that each policy sets exactly its own flag bit, that error codes respond with no array traffic, and that a busy state on the non-target bank is ignored.

// File: rtl/flash_rww_ctrl.sv
module flash_rww_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [TW-1:0] rd_attr,
  output logic          rd_rdy,
  output logic          rd_ack,
  output logic          rd_err,
  output logic [DW-1:0] rd_data,
  input  logic          ctl_we,
  input  logic [5:0]    ctl_wdata,
  input  logic [3:0]    irq_clr,
  output logic [3:0]    irq_flags,
  output logic          irq,
  input  logic [1:0]    bank_done,
  output logic [1:0]    bank_abort,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  output logic [TW-1:0] fl_attr,
  input  logic          fl_rvalid,
  input  logic [DW-1:0] fl_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_STALL} st_t;

  st_t           state, nxt;
  logic [AW-1:0] sv_addr;
  logic [TW-1:0] sv_attr;
  logic [2:0]    ctl_b0, ctl_b1;
  logic          tgt, busy, hit, do_err, do_abort;
  logic [2:0]    pol;
  logic [3:0]    flag_set;

  assign tgt      = (state == S_IDLE) ? rd_addr[AW-1] : sv_addr[AW-1];
  assign pol      = tgt ? ctl_b1 : ctl_b0;
  assign busy     = !bank_done[tgt];
  assign hit      = busy && ((state == S_IDLE && rd_req) || state == S_ISSUE || state == S_WAIT);
  assign do_err   = hit && !pol[2];
  assign do_abort = hit && (pol[2:1] == 2'b10);

  assign flag_set[0] = hit && !tgt && pol == 3'b110;
  assign flag_set[1] = hit &&  tgt && pol == 3'b110;
  assign flag_set[2] = hit && !tgt && pol == 3'b100;
  assign flag_set[3] = hit &&  tgt && pol == 3'b100;

  assign rd_rdy  = (state == S_IDLE);
  assign fl_req  = (state == S_ISSUE) && !busy;
  assign fl_addr = sv_addr;
  assign fl_attr = sv_attr;
  assign irq     = |irq_flags;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (rd_req) nxt = hit ? (do_err ? S_IDLE : S_STALL) : S_ISSUE;
      S_ISSUE: nxt = hit ? (do_err ? S_IDLE : S_STALL) : S_WAIT;
      S_WAIT:  if (hit) nxt = do_err ? S_IDLE : S_STALL;
               else if (fl_rvalid) nxt = S_IDLE;
      S_STALL: if (!busy) nxt = S_ISSUE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sv_addr    <= '0;
      sv_attr    <= '0;
      ctl_b0     <= 3'b111;
      ctl_b1     <= 3'b111;
      irq_flags  <= '0;
      bank_abort <= '0;
      rd_ack     <= 1'b0;
      rd_err     <= 1'b0;
      rd_data    <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && rd_req) begin
        sv_addr <= rd_addr;
        sv_attr <= rd_attr;
      end
      if (ctl_we) begin
        ctl_b0 <= ctl_wdata[2:0];
        ctl_b1 <= ctl_wdata[5:3];
      end
      irq_flags  <= (irq_flags & ~irq_clr) | flag_set;
      bank_abort <= do_abort ? (tgt ? 2'b10 : 2'b01) : 2'b00;
      rd_err     <= do_err;
      rd_ack     <= (state == S_WAIT) && !hit && fl_rvalid;
      if ((state == S_WAIT) && !hit && fl_rvalid) rd_data <= fl_rdata;
    end
  end

endmodule

module flash_rww_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bank_abort,
  input logic       abort_pol0,
  input logic       abort_pol1,
  input logic [3:0] irq_flags,
  input logic [3:0] irq_clr,
  input logic       rd_ack,
  input logic       rd_err,
  input logic       rd_rdy,
  input logic       fl_req,
  input logic       fl_bank,
  input logic [1:0] bank_done
);

  p_abort_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_abort) |=> !(|bank_abort));

  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_abort));

  p_abort_policy0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_abort[0] |-> $past(abort_pol0));

  p_abort_policy1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_abort[1] |-> $past(abort_pol1));

  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));

  p_req_idle_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> bank_done[fl_bank]);

  p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ack && rd_err));

  p_req_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> !rd_rdy);

  p_err_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_rdy);

endmodule

bind flash_rww_ctrl flash_rww_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_abort (bank_abort),
  .abort_pol0 (ctl_b0[2:1] == 2'b10),
  .abort_pol1 (ctl_b1[2:1] == 2'b10),
  .irq_flags  (irq_flags),
  .irq_clr    (irq_clr),
  .rd_ack     (rd_ack),
  .rd_err     (rd_err),
  .rd_rdy     (rd_rdy),
  .fl_req     (fl_req),
  .fl_bank    (fl_addr[AW-1]),
  .bank_done  (bank_done)
);

// File: tb/sim_flash_rww_ctrl.sv
module sim_flash_rww_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 4;

  logic clk = 0, rst_n = 0;
  logic rd_req = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [TW-1:0] rd_attr = '0;
  logic rd_rdy, rd_ack, rd_err;
  logic [DW-1:0] rd_data;
  logic ctl_we = 0;
  logic [5:0] ctl_wdata = '0;
  logic [3:0] irq_clr = '0;
  logic [3:0] irq_flags;
  logic irq;
  logic [1:0] bank_done = 2'b11;
  logic [1:0] bank_abort;
  logic fl_req, fl_rvalid;
  logic [AW-1:0] fl_addr;
  logic [TW-1:0] fl_attr;
  logic [DW-1:0] fl_rdata;

  always #(CLK_NS/2) clk = ~clk;

  flash_rww_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u0 (.*);

  logic v1 = 0, v2 = 0;
  logic [AW-1:0] a1 = '0, a2 = '0;
  logic [AW-1:0] last_addr = '0;
  logic [TW-1:0] last_attr = '0;
  int req_cnt = 0, ab0_cnt = 0, ab1_cnt = 0;
  always @(posedge clk) begin
    v1 <= fl_req; v2 <= v1;
    a1 <= fl_addr; a2 <= a1;
    if (fl_req) begin req_cnt++; last_addr <= fl_addr; last_attr <= fl_attr; end
    if (bank_abort[0]) ab0_cnt++;
    if (bank_abort[1]) ab1_cnt++;
  end
  assign fl_rvalid = v2;
  assign fl_rdata  = {a2, ~a2};

  int nvec = 0, nbad = 0;
  logic [DW:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (rd_ack || rd_err)) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected response", {rd_err, rd_data}, 0);
      else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[DW]) chk(rd_err && !rd_ack, t, {rd_ack, rd_err}, 1);
        else       chk(rd_ack && !rd_err && rd_data == e[DW-1:0], t, {rd_err, rd_data}, e[DW-1:0]);
      end
    end
  end

  task automatic issue(input logic [AW-1:0] a, input logic [TW-1:0] t, input bit err, input string tag);
    @(negedge clk);
    while (!rd_rdy) @(negedge clk);
    exp_q.push_back({err, a, ~a});
    tag_q.push_back(tag);
    rd_req = 1; rd_addr = a; rd_attr = t;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R3 response outstanding", exp_q.size(), 0);
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic [2:0] p1, input logic [2:0] p0);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = {p1, p0};
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    irq_clr = m;
    @(negedge clk);
    irq_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int r0, a0, a1c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_rdy == 1, "R1 ready after reset", rd_rdy, 1);
    chk(irq_flags == 0 && irq == 0, "R1 flags after reset", {irq, irq_flags}, 0);
    chk(bank_abort == 0, "R1 abort after reset", bank_abort, 0);

    issue(16'h0123, 4'h1, 0, "R3 plain read bank0");
    chk(rd_rdy == 0, "R10 ready low after accept", rd_rdy, 0);
    issue(16'h8456, 4'h2, 0, "R10 back-to-back read bank1");
    wait_idle();

    bank_done = 2'b01;
    issue(16'h0077, 4'h3, 0, "R2 other bank busy ignored");
    wait_idle();
    bank_done = 2'b11;

    bank_done[0] = 0;
    issue(16'h0040, 4'h4, 0, "R3 stall then data");
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 1, "R3 held while busy", exp_q.size(), 1);
    chk(rd_rdy == 0, "R10 ready low during stall", rd_rdy, 0);
    chk(irq_flags == 0 && ab0_cnt == 0, "R3 no flag no abort", {ab0_cnt[3:0], irq_flags}, 0);
    bank_done[0] = 1;
    wait_idle();

    set_ctl(3'b110, 3'b111);
    bank_done[1] = 0;
    issue(16'h8100, 4'h5, 0, "R5 notify read");
    repeat (5) @(negedge clk);
    chk(irq_flags == 4'b0010 && irq == 1, "R5 notify flag bank1", {irq, irq_flags}, 5'b10010);
    bank_done[1] = 1;
    wait_idle();
    chk(irq_flags == 4'b0010, "R9 flag sticky", irq_flags, 4'b0010);
    clear(4'b0001);
    chk(irq_flags == 4'b0010, "R9 other bit clear ignored", irq_flags, 4'b0010);
    clear(4'b0010);
    chk(irq_flags == 0 && irq == 0, "R9 write-1 clear", {irq, irq_flags}, 0);

    set_ctl(3'b111, 3'b101);
    a0 = ab0_cnt; a1c = ab1_cnt;
    bank_done[0] = 0;
    issue(16'h0200, 4'h6, 0, "R6 abort read replay");
    repeat (5) @(negedge clk);
    chk(ab0_cnt - a0 == 1 && ab1_cnt == a1c, "R6 single abort pulse bank0", ab0_cnt - a0, 1);
    chk(irq_flags == 0, "R6 no flag", irq_flags, 0);
    bank_done[0] = 1;
    wait_idle();

    set_ctl(3'b100, 3'b101);
    a1c = ab1_cnt;
    bank_done[1] = 0;
    issue(16'h8300, 4'h7, 0, "R7 abort with flag");
    repeat (5) @(negedge clk);
    chk(ab1_cnt - a1c == 1, "R7 abort pulse bank1", ab1_cnt - a1c, 1);
    chk(irq_flags == 4'b1000 && irq == 1, "R7 abort flag bank1", irq_flags, 4'b1000);
    bank_done[1] = 1;
    wait_idle();
    clear(4'b1000);

    set_ctl(3'b100, 3'b011);
    bank_done[0] = 0;
    r0 = req_cnt;
    issue(16'h0400, 4'h8, 1, "R8 error on busy");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8 error without stall", exp_q.size(), 0);
    chk(req_cnt == r0 && irq_flags == 0, "R8 no array access no flag", req_cnt - r0, 0);
    bank_done[0] = 1;
    issue(16'h0404, 4'h9, 0, "R8 idle bank reads normally");
    wait_idle();

    set_ctl(3'b111, 3'b111);
    r0 = req_cnt;
    issue(16'h0500, 4'hA, 0, "R4 done drop mid read");
    @(negedge clk);
    bank_done[0] = 0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 1 && rd_rdy == 0, "R4 stalled mid read", exp_q.size(), 1);
    bank_done[0] = 1;
    wait_idle();
    chk(req_cnt - r0 == 2, "R4 replayed once", req_cnt - r0, 2);
    chk(last_addr == 16'h0500 && last_attr == 4'hA, "R4 replay addr attr", {last_addr, last_attr}, {16'h0500, 4'hA});

    set_ctl(3'b111, 3'b000);
    bank_done[0] = 0;
    issue(16'h0010, 4'hB, 1, "R11 new policy applied");
    wait_idle();
    bank_done[0] = 1;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule